// File: doc/BRIEF.md
# Three-Channel Tone and Noise Mixer

This block is the register and waveform core of a programmable sound generator. A processor writes sixteen byte-wide registers through a simple address/data port. Each stored value is cut down to its legal width, and every register can be read back. Three independent square-wave tone channels and one shared pseudo-random noise source run from the system clock. A fixed divide-by-16 prescaler sets their pace.

Each channel's tone is set by a 12-bit period. The low 8 bits come from a fine register and the top 4 bits from a coarse register. Each tone half-cycle lasts 16 × period input clocks, so a larger period gives a lower pitch. A mixer register uses active-low enables to let tone and noise through for each channel. The channel's amplitude is either its fixed 4-bit volume or, when the volume register's mode bit is set, a 4-bit envelope level supplied from outside. A channel whose gate is closed outputs 0.

Conversion to analogue, the general-purpose I/O ports and the envelope generator are outside this block. The two I/O bytes and the three envelope-control bytes are only stored.

Top module: `psg_tone_mixer`

## Requirements
- R1: After a synchronous active-low reset, all sixteen registers read 0 and all three amplitude outputs are 0.
- R2: A write stores `wr_data` masked to the register's width and the read port returns that stored value. The widths are: addresses 1, 3, 5 and 13 keep bits [3:0]; addresses 6, 8, 9 and 10 keep bits [4:0]; all other addresses keep all 8 bits. Unused bits read as 0, and a write to one address leaves every other address unchanged.
- R3: Channel A, B or C takes its period P from the fine register at address 0, 2 or 4 (bits [7:0]) and the coarse register at address 1, 3 or 5 (bits [11:8]). Each half-cycle of its tone lasts exactly 16 × P clocks.
- R4: A tone period of 0 behaves as a period of 1, giving a half-cycle of 16 clocks.
- R5: The noise bit comes from a 17-bit LFSR. The LFSR steps once every 16 × N clocks, where N is address 6 bits [4:0] and 0 acts as 1. A channel that passes only noise therefore changes amplitude only at intervals that are whole multiples of 16 × N clocks.
- R6: The mixer at address 7 is active-low. Bit k (k = 0..2, A..C) turns off the tone for channel k and bit 3+k turns off its noise. A channel with both enable bits set to 1 outputs its amplitude constantly.
- R7: The gate of a channel is (tone OR tone-off) AND (noise OR noise-off). When the gate is 0 the channel outputs amplitude 0.
- R8: Channels A, B and C take their volume from address 8, 9 and 10. Bit 4 of the volume register is the envelope-mode bit. When it is 1, an open gate outputs `env_level` and bits [3:0] are ignored. When it is 0, an open gate outputs bits [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the tone time base |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_addr | input | 4 | Register address for writes and reads |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Masked contents of the addressed register (combinational) |
| env_level | input | 4 | Shared envelope level from an external generator |
| amp_a | output | 4 | Channel A amplitude code |
| amp_b | output | 4 | Channel B amplitude code |
| amp_c | output | 4 | Channel C amplitude code |

## Verification
The assertions assume that `wr_en`, `reg_addr` and `wr_data` are stable around each rising edge. They also assume that a period register may be rewritten at any time, so a tone counter can briefly sit above a newly lowered period. The bench changes inputs only on falling edges. It throws away the first tone edge after every period or mixer write before it times a half-cycle, so every measured interval comes from a settled counter. Noise is judged only by the spacing of its edges, which follows from the step rate whatever the LFSR's phase.

// File: rtl/psg_pkg.sv
// Package psg_pkg
// Shared sizes and register layout for the tone/noise mixer.
// Assumes a 16-entry byte-wide register space.
package psg_pkg;
    localparam int NUM_CH   = 3;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 1 << ADDR_W;
    localparam int PER_W    = 12;
    localparam int FINE_W   = 8;
    localparam int NPER_W   = 5;
    localparam int VOL_W    = 4;
    localparam int PRESCALE = 16;
    localparam int LFSR_W   = 17;

    localparam logic [ADDR_W-1:0] A_NOISE = 4'd6;
    localparam logic [ADDR_W-1:0] A_MIX   = 4'd7;
    localparam logic [ADDR_W-1:0] A_VOL0  = 4'd8;

    // Legal-width mask for each register address.
    function automatic logic [DATA_W-1:0] reg_mask(input logic [ADDR_W-1:0] a);
        case (a)
            4'd1, 4'd3, 4'd5, 4'd13: reg_mask = 8'h0F;
            4'd6, 4'd8, 4'd9, 4'd10: reg_mask = 8'h1F;
            default:                 reg_mask = 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/psg_regfile.sv
// Module psg_regfile
// Holds the sixteen sound registers, masks writes to legal width and
// splits the stored bytes into the per-channel fields.
// Assumes the write strobe is synchronous to clk.
module psg_regfile
    import psg_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [DATA_W-1:0]             rd_data,
    output logic [NUM_CH-1:0][PER_W-1:0]  period,
    output logic [NPER_W-1:0]             noise_per,
    output logic [DATA_W-1:0]             mixer,
    output logic [NUM_CH-1:0][VOL_W:0]    volume
);
    logic [DATA_W-1:0] regs [NUM_REGS];

    // Store masked write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[reg_addr] <= wr_data & reg_mask(reg_addr);
        end
    end

    // Read port returns the stored value.
    always_comb rd_data = regs[reg_addr];

    assign noise_per = regs[A_NOISE][NPER_W-1:0];
    assign mixer     = regs[A_MIX];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_fields
        assign period[ch] = {regs[2*ch+1][PER_W-FINE_W-1:0], regs[2*ch]};
        assign volume[ch] = regs[int'(A_VOL0) + ch][VOL_W:0];
    end

    // R2: coarse period bytes never hold bits above the nibble.
    a_r2_coarse_masked: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && reg_addr == 4'd1 |=> regs[1][7:4] == 4'd0);
endmodule

// File: rtl/psg_prescaler.sv
// Module psg_prescaler
// Emits a one-clock tick every DIV input clocks; the shared time base.
// Assumes DIV >= 2.
module psg_prescaler #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(DIV);
    logic [CW-1:0] cnt;

    // Free-running divide counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt <= '0;
        else if (cnt == CW'(DIV - 1))     cnt <= '0;
        else                              cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == CW'(DIV - 1));

    // R3: ticks are never back to back.
    a_r3_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/psg_tone_chan.sv
// Module psg_tone_chan
// Square-wave tone: counts prescaler ticks and flips its output each time
// the count reaches the period. Period 0 is treated as 1.
// Assumes tick is a single-cycle pulse.
module psg_tone_chan #(
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [PER_W-1:0] period,
    output logic             tone
);
    logic [PER_W-1:0] cnt;
    logic [PER_W:0]   nxt;
    logic [PER_W:0]   eff;

    // Next count and effective period.
    always_comb begin
        nxt = {1'b0, cnt} + 1'b1;
        eff = (period == '0) ? (PER_W+1)'(1) : {1'b0, period};
    end

    // Count ticks and flip the tone on reaching the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tone <= 1'b0;
        end else if (tick) begin
            if (nxt >= eff) begin
                cnt  <= '0;
                tone <= ~tone;
            end else begin
                cnt  <= nxt[PER_W-1:0];
            end
        end
    end

    // R3: the tone only moves on a prescaler tick.
    a_r3_tone_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tone));
    // R4: a zero period flips on every tick.
    a_r4_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
        tick && period == '0 |=> tone != $past(tone));
endmodule

// File: rtl/psg_noise.sv
// Module psg_noise
// Shared noise source: a 17-bit LFSR (feedback bit0 xor bit3) stepped
// once every noise-period ticks; period 0 is treated as 1.
// Assumes tick is a single-cycle pulse.
module psg_noise #(
    parameter int NPER_W = 5,
    parameter int LFSR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [NPER_W-1:0] noise_per,
    output logic              noise_bit
);
    logic [NPER_W-1:0] cnt;
    logic [NPER_W:0]   nxt;
    logic [NPER_W:0]   eff;
    logic [LFSR_W-1:0] lfsr;

    // Next count and effective period.
    always_comb begin
        nxt = {1'b0, cnt} + 1'b1;
        eff = (noise_per == '0) ? (NPER_W+1)'(1) : {1'b0, noise_per};
    end

    // Divide ticks and shift the LFSR.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            lfsr <= LFSR_W'(1);
        end else if (tick) begin
            if (nxt >= eff) begin
                cnt  <= '0;
                lfsr <= {lfsr[0] ^ lfsr[3], lfsr[LFSR_W-1:1]};
            end else begin
                cnt  <= nxt[NPER_W-1:0];
            end
        end
    end

    assign noise_bit = lfsr[0];

    // R5: the LFSR never locks up at zero.
    a_r5_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != '0);
    // R5: the LFSR only moves on a prescaler tick.
    a_r5_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(lfsr));
endmodule

// File: rtl/psg_tone_mixer.sv
// Module psg_tone_mixer
// Top: register file, prescaler, three tone channels and a noise source,
// combined by an active-low mixer into three 4-bit amplitude codes.
// Assumes env_level comes from an external envelope generator.
module psg_tone_mixer
    import psg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [VOL_W-1:0]  env_level,
    output logic [VOL_W-1:0]  amp_a,
    output logic [VOL_W-1:0]  amp_b,
    output logic [VOL_W-1:0]  amp_c
);
    logic [NUM_CH-1:0][PER_W-1:0] period;
    logic [NUM_CH-1:0][VOL_W:0]   volume;
    logic [NPER_W-1:0]            noise_per;
    logic [DATA_W-1:0]            mixer;
    logic                         tick;
    logic                         noise_bit;
    logic [NUM_CH-1:0]            tone;
    logic [NUM_CH-1:0]            gate;
    logic [NUM_CH-1:0][VOL_W-1:0] amp;

    psg_regfile i_regs (
        .clk, .rst_n, .wr_en, .reg_addr, .wr_data, .rd_data,
        .period, .noise_per, .mixer, .volume
    );

    psg_prescaler #(.DIV(PRESCALE)) i_pre (.clk, .rst_n, .tick);

    psg_noise #(.NPER_W(NPER_W), .LFSR_W(LFSR_W)) i_noise (
        .clk, .rst_n, .tick, .noise_per, .noise_bit
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        psg_tone_chan #(.PER_W(PER_W)) i_tone (
            .clk, .rst_n, .tick, .period(period[ch]), .tone(tone[ch])
        );

        // Gate and amplitude select for this channel.
        always_comb begin
            gate[ch] = (tone[ch] | mixer[ch]) & (noise_bit | mixer[NUM_CH + ch]);
            if (!gate[ch])            amp[ch] = '0;
            else if (volume[ch][VOL_W]) amp[ch] = env_level;
            else                      amp[ch] = volume[ch][VOL_W-1:0];
        end

        // R6: both sources off means a permanently open gate.
        a_r6_all_off_open: assert property (@(posedge clk) disable iff (!rst_n)
            mixer[ch] && mixer[NUM_CH + ch] |-> amp[ch] != '0 || volume[ch] == '0
                || (volume[ch][VOL_W] && env_level == '0));
        // R8: envelope mode ignores the fixed level.
        a_r8_env_follow: assert property (@(posedge clk) disable iff (!rst_n)
            gate[ch] && volume[ch][VOL_W] |-> amp[ch] == env_level);
    end

    assign amp_a = amp[0];
    assign amp_b = amp[1];
    assign amp_c = amp[2];
endmodule

// File: tb/test_psg_tone_mixer.sv
module test_psg_tone_mixer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [3:0] env_level = '0;
    logic [3:0] amp_a, amp_b, amp_c;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    psg_tone_mixer i_psg_tone_mixer (
        .clk, .rst_n, .wr_en, .reg_addr, .wr_data, .rd_data,
        .env_level, .amp_a, .amp_b, .amp_c
    );

    // Vector table: {address, write data, expected read-back}.
    localparam logic [19:0] VEC [16] = '{
        {4'd0,  8'hA5, 8'hA5}, {4'd1,  8'hFB, 8'h0B},
        {4'd2,  8'h3C, 8'h3C}, {4'd3,  8'h77, 8'h07},
        {4'd4,  8'hFF, 8'hFF}, {4'd5,  8'hE2, 8'h02},
        {4'd6,  8'hFF, 8'h1F}, {4'd7,  8'hC9, 8'hC9},
        {4'd8,  8'hF3, 8'h13}, {4'd9,  8'hEE, 8'h0E},
        {4'd10, 8'hB8, 8'h18}, {4'd11, 8'h81, 8'h81},
        {4'd12, 8'h42, 8'h42}, {4'd13, 8'hDD, 8'h0D},
        {4'd14, 8'h5A, 8'h5A}, {4'd15, 8'hF0, 8'hF0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = rd_data;
    endtask

    function automatic logic [3:0] amp_of(input int idx);
        return idx == 0 ? amp_a : (idx == 1 ? amp_b : amp_c);
    endfunction

    // Clocks (sampled on falling edges) until the channel's amplitude changes.
    task automatic edge_gap(input int idx, input int limit, output int n);
        logic [3:0] prev;
        prev = amp_of(idx);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (amp_of(idx) == prev && n < limit);
    endtask

    initial begin
        int gap;
        logic [7:0] d;
        // Reset.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d);
            check(d == 8'h00, "R1 reg after reset", d, 0);
        end
        check(amp_a == 0 && amp_b == 0 && amp_c == 0, "R1 amps after reset",
              {amp_a, amp_b, amp_c}, 0);

        // R2: vector table walk, then re-read all for cross-talk.
        foreach (VEC[i]) begin
            wr(VEC[i][19:16], VEC[i][15:8]);
            rd(VEC[i][19:16], d);
            check(d == VEC[i][7:0], "R2 masked read-back", d, VEC[i][7:0]);
        end
        foreach (VEC[i]) begin
            rd(VEC[i][19:16], d);
            check(d == VEC[i][7:0], "R2 no cross-talk", d, VEC[i][7:0]);
        end

        // R6: both sources off on all channels; constant volume.
        wr(4'd7, 8'h3F);
        wr(4'd8, 8'h09); wr(4'd9, 8'h04); wr(4'd10, 8'h0F);
        begin
            int changes = 0;
            for (int k = 0; k < 200; k++) begin
                @(negedge clk);
                if (amp_a != 4'd9) changes++;
            end
            check(changes == 0, "R6 all off holds volume", changes, 0);
        end
        check(amp_b == 4'd4 && amp_c == 4'd15, "R6 B/C constant", {amp_b, amp_c}, {4'd4, 4'd15});

        // R8: envelope mode on A, fixed bits ignored.
        wr(4'd8, 8'h1A);
        env_level = 4'd5;
        @(negedge clk);
        check(amp_a == 4'd5, "R8 env level used", amp_a, 5);
        env_level = 4'd12;
        @(negedge clk);
        check(amp_a == 4'd12, "R8 env follows input", amp_a, 12);
        check(amp_b == 4'd4, "R8 fixed volume on B", amp_b, 4);

        // R3/R7: tone only on A, period 5 -> 80 clocks per half cycle.
        wr(4'd8, 8'h07);
        wr(4'd0, 8'h05); wr(4'd1, 8'h00);
        wr(4'd7, 8'h3E);
        edge_gap(0, 5000, gap);
        edge_gap(0, 5000, gap);
        check(gap == 80, "R3 half period P=5", gap, 80);
        edge_gap(0, 5000, gap);
        check(gap == 80, "R3 half period P=5 again", gap, 80);
        begin
            bit seen0 = 0, seen7 = 0;
            for (int k = 0; k < 200; k++) begin
                @(negedge clk);
                if (amp_a == 0) seen0 = 1;
                if (amp_a == 7) seen7 = 1;
            end
            check(seen0 && seen7, "R7 gate closes to zero", {seen0, seen7}, 3);
        end

        // R3: channel B coarse+fine, P=0x102 -> 4128 clocks.
        wr(4'd2, 8'h02); wr(4'd3, 8'h01);
        wr(4'd7, 8'h3D);
        edge_gap(1, 10000, gap);
        edge_gap(1, 10000, gap);
        check(gap == 4128, "R3 half period P=0x102", gap, 4128);

        // R4: channel C period 0 -> 16 clocks.
        wr(4'd4, 8'h00); wr(4'd5, 8'h00);
        wr(4'd7, 8'h3B);
        edge_gap(2, 1000, gap);
        edge_gap(2, 1000, gap);
        check(gap == 16, "R4 zero period", gap, 16);

        // R5: noise only on A, N=3 -> edges at multiples of 48 clocks.
        wr(4'd6, 8'h03);
        wr(4'd7, 8'h37);
        edge_gap(0, 5000, gap);
        for (int k = 0; k < 6; k++) begin
            edge_gap(0, 5000, gap);
            check(gap < 5000 && gap % 48 == 0, "R5 noise edge spacing", gap, 48);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule